// File: doc/BRIEF.md
# Decode-Stage Load-Use Stall and Branch Flush Controller

This block sits beside the decode stage of a five-stage in-order pipeline. Each cycle it compares the destination register of the instruction in the execute stage against the two source registers of the instruction in decode. When the execute-stage instruction is a memory read whose destination matches either source, the loaded value cannot arrive in time even with forwarding. The block then stalls decode for one cycle. While stalled, it holds the program counter and the fetch/decode pipeline register, and it selects an all-zero control word into the decode/execute register, so that a bubble travels down the pipe.

Branches are resolved in decode by a comparator outside this block. That comparator delivers a single taken flag. On a taken branch the block raises a flush for the fetch/decode register, which discards the one wrongly fetched instruction. A stall outranks a flush, because the branch in decode is held and is evaluated again on the next cycle.

The stall is limited to a single cycle. After one bubble, the load has moved on to the memory stage and its result can be forwarded. The decision outputs are combinational from the inputs and a one-bit history register. This lets the hold and the bubble take effect in the same cycle in which the hazard is seen.

Top module: `hz_decode_ctrl`

## Requirements
- R1: When `idex_mem_read_i` is 1 and `idex_dest_i` equals `ifid_src_a_i` or `ifid_src_b_i`, and the previous cycle was not a stall cycle and reset is low, the block stalls (`bubble_sel_o` = 1).
- R2: When `idex_mem_read_i` is 0, or the destination matches neither source, no stall occurs, whatever the register values are.
- R3: `pc_write_o` and `ifid_write_o` are both 0 in a stall cycle and both 1 in every other cycle.
- R4: `bubble_sel_o` is 1 exactly in stall cycles; 1 means that the control word entering decode/execute is zeroed.
- R5: A stall never lasts longer than one cycle. In the cycle after a stall, the same hazard inputs produce no stall.
- R6: `ifid_flush_o` is 1 when `br_taken_i` is 1 and the cycle is not a stall cycle; it is 0 when `br_taken_i` is 0.
- R7: If a stall and a taken branch occur in the same cycle, the stall wins: `ifid_flush_o` is 0 and the hold outputs act as in R3.
- R8: While `rst` is 1 there is no stall and no flush, and both write enables are 1. In the first cycle after reset, a hazard stalls.
- R9: In a pipeline where a load is followed directly by an instruction that uses the loaded register, exactly one bubble is inserted and the PC is held for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| idex_mem_read_i | input | 1 | Instruction in execute reads data memory |
| idex_dest_i | input | REG_ADDR_W | Destination register of the execute-stage instruction |
| ifid_src_a_i | input | REG_ADDR_W | First source register of the decode-stage instruction |
| ifid_src_b_i | input | REG_ADDR_W | Second source register of the decode-stage instruction |
| br_taken_i | input | 1 | Branch in decode resolved taken |
| pc_write_o | output | 1 | Program counter update enable |
| ifid_write_o | output | 1 | Fetch/decode register load enable |
| bubble_sel_o | output | 1 | Select zero control word into decode/execute |
| ifid_flush_o | output | 1 | Clear fetch/decode register |

## Verification
The bench sweeps every combination of memory-read flag, destination, both sources and branch flag on a 3-bit register address. It checks each combination once from a clean history and once again with the inputs held. This exposes a design that compares only one source, ignores the memory-read flag, or stalls again forever on a held hazard (which would deadlock the pipe). A taken branch that arrives together with a stall is checked for suppression. A controller that flushes there would lose the branch instruction it was supposed to hold. A small pipeline model then counts the bubbles and the cycles in which the PC is held, so a controller that stalls twice or not at all shows up as a wrong count.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Number of source operands that an instruction in decode can name.
  localparam int unsigned NUM_SRC = 2;

  // Stall history: whether the previous cycle was a stall cycle.
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HELD = 1'b1
  } hold_state_e;
endpackage

// File: rtl/hz_src_match.sv
// Compares one destination against a packed set of source registers.
module hz_src_match #(
  parameter int unsigned W = 5,
  parameter int unsigned N = 2
) (
  input  logic         en_i,
  input  logic [W-1:0] dest_i,
  input  logic [N*W-1:0] srcs_i,
  output logic         hit_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (srcs_i[g*W +: W] == dest_i);
  end

  assign hit_o = en_i & (|eq);
endmodule

// File: rtl/hz_stall_limiter.sv
// Turns a raw hazard into a stall that lasts at most one cycle.
module hz_stall_limiter
  import hz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hazard_i,
  output logic stall_o
);
  hold_state_e state_q;

  assign stall_o = hazard_i & ~rst & (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= stall_o ? ST_HELD : ST_RUN;
    end
  end
endmodule

// File: rtl/hz_flush_gate.sv
// A flush of the fetch/decode register yields to a stall.
module hz_flush_gate (
  input  logic rst,
  input  logic br_taken_i,
  input  logic stall_i,
  output logic flush_o
);
  assign flush_o = br_taken_i & ~stall_i & ~rst;
endmodule

// File: rtl/hz_decode_ctrl.sv
module hz_decode_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  idex_mem_read_i,
  input  logic [REG_ADDR_W-1:0] idex_dest_i,
  input  logic [REG_ADDR_W-1:0] ifid_src_a_i,
  input  logic [REG_ADDR_W-1:0] ifid_src_b_i,
  input  logic                  br_taken_i,
  output logic                  pc_write_o,
  output logic                  ifid_write_o,
  output logic                  bubble_sel_o,
  output logic                  ifid_flush_o
);
  localparam int unsigned SRC_BUS_W = NUM_SRC * REG_ADDR_W;

  logic [SRC_BUS_W-1:0] src_bus;
  logic                 hazard;
  logic                 stall;

  // Source B occupies the upper slice and source A the lower slice.
  assign src_bus = {ifid_src_b_i, ifid_src_a_i};

  hz_src_match #(
    .W (REG_ADDR_W),
    .N (NUM_SRC)
  ) u_match (
    .en_i   (idex_mem_read_i),
    .dest_i (idex_dest_i),
    .srcs_i (src_bus),
    .hit_o  (hazard)
  );

  hz_stall_limiter u_limit (
    .clk      (clk),
    .rst      (rst),
    .hazard_i (hazard),
    .stall_o  (stall)
  );

  hz_flush_gate u_flush (
    .rst        (rst),
    .br_taken_i (br_taken_i),
    .stall_i    (stall),
    .flush_o    (ifid_flush_o)
  );

  assign bubble_sel_o = stall;
  assign pc_write_o   = ~stall;
  assign ifid_write_o = ~stall;
endmodule

// File: rtl/hz_decode_ctrl_chk.sv
module hz_decode_ctrl_chk #(
  parameter int unsigned W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         idex_mem_read_i,
  input logic [W-1:0] idex_dest_i,
  input logic [W-1:0] ifid_src_a_i,
  input logic [W-1:0] ifid_src_b_i,
  input logic         br_taken_i,
  input logic         pc_write_o,
  input logic         ifid_write_o,
  input logic         bubble_sel_o,
  input logic         ifid_flush_o
);
  logic raw_hz;
  assign raw_hz = idex_mem_read_i &&
                  (idex_dest_i == ifid_src_a_i || idex_dest_i == ifid_src_b_i);

  p_cause_r2: assert property (@(posedge clk) disable iff (rst)
    bubble_sel_o |-> raw_hz);

  p_hold_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (pc_write_o == ifid_write_o) && (pc_write_o != bubble_sel_o));

  p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    bubble_sel_o |=> !bubble_sel_o);

  p_rearm_r1: assert property (@(posedge clk) disable iff (rst)
    (raw_hz && !bubble_sel_o) |=> (raw_hz |-> bubble_sel_o));

  p_flush_src_r6: assert property (@(posedge clk) disable iff (rst)
    ifid_flush_o |-> br_taken_i);

  p_stall_wins_r7: assert property (@(posedge clk) disable iff (rst)
    bubble_sel_o |-> !ifid_flush_o);

  always_comb begin
    if (rst) begin
      a_reset_quiet_r8: assert (pc_write_o && !ifid_flush_o && !bubble_sel_o);
    end
  end
endmodule

bind hz_decode_ctrl hz_decode_ctrl_chk #(.W(REG_ADDR_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .idex_mem_read_i (idex_mem_read_i),
  .idex_dest_i     (idex_dest_i),
  .ifid_src_a_i    (ifid_src_a_i),
  .ifid_src_b_i    (ifid_src_b_i),
  .br_taken_i      (br_taken_i),
  .pc_write_o      (pc_write_o),
  .ifid_write_o    (ifid_write_o),
  .bubble_sel_o    (bubble_sel_o),
  .ifid_flush_o    (ifid_flush_o)
);

// File: tb/hz_decode_ctrl_tb_top.sv
module hz_decode_ctrl_tb_top;
  localparam int unsigned W = 3;
  localparam int unsigned NV = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mr = 1'b0;
  logic [W-1:0] dst = '0, sa = '0, sb = '0;
  logic br = 1'b0;
  logic pcw, ifw, bub, fl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hz_decode_ctrl #(.REG_ADDR_W(W)) dut_i (
    .clk (clk), .rst (rst),
    .idex_mem_read_i (mr), .idex_dest_i (dst),
    .ifid_src_a_i (sa), .ifid_src_b_i (sb), .br_taken_i (br),
    .pc_write_o (pcw), .ifid_write_o (ifw),
    .bubble_sel_o (bub), .ifid_flush_o (fl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  // Pipeline model: per slot {is_load, dest, src_a, src_b}.
  typedef struct packed {
    logic         ld;
    logic [W-1:0] d;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } ins_t;

  function automatic ins_t imem(input int pc);
    ins_t r;
    case (pc)
      0:       r = '{ld: 1'b1, d: 3'd4, a: 3'd1, b: 3'd2};
      1:       r = '{ld: 1'b0, d: 3'd5, a: 3'd4, b: 3'd3};
      2:       r = '{ld: 1'b0, d: 3'd6, a: 3'd1, b: 3'd2};
      default: r = '{ld: 1'b0, d: 3'd7, a: 3'd3, b: 3'd1};
    endcase
    return r;
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: quiet during reset, even with hazard and taken branch on the inputs
    mr = 1'b1; dst = 3'd2; sa = 3'd2; sb = 3'd0; br = 1'b1;
    next_cycle();
    next_cycle();
    @(negedge clk);
    chk("R8 reset pc_write", pcw, 1);
    chk("R8 reset ifid_write", ifw, 1);
    chk("R8 reset bubble", bub, 0);
    chk("R8 reset flush", fl, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R8 first-cycle stall", bub, 1);
    chk("R7 flush suppressed", fl, 0);
    next_cycle();
    @(negedge clk);
    chk("R5 no second stall", bub, 0);
    chk("R6 flush after stall", fl, 1);

    // Exhaustive sweep: clean history, then the same inputs held.
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < NV; d++)
        for (int a = 0; a < NV; a++)
          for (int b = 0; b < NV; b++)
            for (int t = 0; t < 2; t++) begin
              bit hz;
              next_cycle();
              mr = 1'b0; br = 1'b0;
              next_cycle();
              mr = m[0]; dst = d[W-1:0]; sa = a[W-1:0]; sb = b[W-1:0]; br = t[0];
              hz = (m == 1) && (d == a || d == b);
              @(negedge clk);
              chk(hz ? "R1 stall" : "R2 no stall", bub, int'(hz));
              chk("R3 pc_write", pcw, int'(!hz));
              chk("R3 ifid_write", ifw, int'(!hz));
              chk("R4 bubble select", bub, pcw ? 0 : 1);
              chk(hz ? "R7 stall over flush" : "R6 flush", fl, int'(t == 1 && !hz));
              next_cycle();
              @(negedge clk);
              chk("R5 held inputs no stall", bub, 0);
              chk("R6 flush held", fl, t);
            end

    // R9: load followed by a dependent instruction
    begin
      int pc = 0;
      ins_t ifid = '0, idex = '0;
      int bubbles = 0, held = 0;
      next_cycle();
      mr = 1'b0; br = 1'b0;
      next_cycle();
      for (int c = 0; c < 8; c++) begin
        bit s_pcw, s_ifw, s_bub;
        mr = idex.ld; dst = idex.d; sa = ifid.a; sb = ifid.b;
        @(negedge clk);
        s_pcw = pcw; s_ifw = ifw; s_bub = bub;
        if (s_bub) bubbles++;
        if (!s_pcw) held++;
        @(posedge clk);
        #1;
        idex = s_bub ? ins_t'('0) : ifid;
        if (s_ifw) ifid = imem(pc);
        if (s_pcw) pc++;
      end
      chk("R9 bubble count", bubbles, 1);
      chk("R9 pc held cycles", held, 1);
      chk("R9 pc progressed", pc, 7);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule